// File: doc/BRIEF.md
# Sobel Four-Orientation Edge Classifier

This block takes one 3x3 window of 8-bit grayscale pixels per clock and decides whether the centre pixel lies on an edge. It forms a signed Sobel-style derivative along four orientations: the two diagonals, the vertical axis and the horizontal axis. It then takes the largest absolute derivative and adds one eighth of the absolute derivative at right angles to it. If that weighted sum reaches a fixed threshold, the pixel is marked as an edge and given one of eight compass directions. The direction points toward the brighter side of the edge.

The window is formed upstream, for example by a line buffer. It arrives as a flat 72-bit vector with a valid strobe. The result leaves a fixed two-stage pipeline exactly two clocks later. Back-to-back windows are accepted with no stall.

Top module: `sobel_edge_classifier`

## Requirements
- R1: With pixel t[r][c] at bits [(3r+c)*8 +: 8] of `win_i` (row 0 at the top), the block forms four signed 12-bit derivatives. Diagonal A = (t01+2t02+t12)-(t10+2t20+t21). Vertical = (t00+2t01+t02)-(t20+2t21+t22). Horizontal = (t02+2t12+t22)-(t00+2t10+t20). Diagonal B = (t10+2t00+t01)-(t21+2t22+t12). Full-scale inputs (magnitude 1020) do not overflow.
- R2: Direction codes are N=000, NE=001, E=010, SE=011, S=100, SW=101, W=110, NW=111. A non-negative derivative maps diagonal A to NE, vertical to N, horizontal to E and diagonal B to NW. A negative derivative maps them to SW, S, W and SE respectively.
- R3: The maximum magnitude is the largest of the four absolute derivatives. On a tie, the first orientation in the order diagonal A, vertical, horizontal, diagonal B wins.
- R4: The perpendicular magnitude comes from the paired orientation: vertical pairs with horizontal, and diagonal A pairs with diagonal B. It is divided by 8 with truncation.
- R5: `edge_o` is 1 exactly when max + perp/8 >= THRESH (default 80), and `dir_o` then carries the direction of the maximum. Otherwise `edge_o` is 0 and `dir_o` is 000.
- R6: `edge_valid_o` equals `win_valid_i` from two clocks earlier, and one new window is accepted on every clock.
- R7: A window presented with `win_valid_i` low has no effect on the outputs. Whenever `edge_valid_o` is 0, both `edge_o` and `dir_o` are 0.
- R8: While `rst_ni` is low, all outputs are 0, and any windows in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_valid_i | input | 1 | Window valid strobe |
| win_i | input | 72 | 3x3 window, pixel (r,c) at bits [(3r+c)*8 +: 8] |
| edge_valid_o | output | 1 | Result valid, two clocks after input |
| edge_o | output | 1 | Edge flag |
| dir_o | output | 3 | Edge direction code |

## Verification
The assertions check the following on every cycle:
- the two-clock valid latency;
- quiet outputs whenever the result is not valid;
- a zero direction whenever no edge is flagged;
- cleared outputs during reset;
- that an all-zero set of derivatives in the middle stage never yields an edge.

The derivative arithmetic, the sign-to-direction mapping, tie priority, the perpendicular pairing with truncation, and the exact threshold boundary (80 versus 79) can only be shown by the bench's windows and their hand-derived results.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

  typedef enum logic [2:0] {
    DIR_N  = 3'd0,
    DIR_NE = 3'd1,
    DIR_E  = 3'd2,
    DIR_SE = 3'd3,
    DIR_S  = 3'd4,
    DIR_SW = 3'd5,
    DIR_W  = 3'd6,
    DIR_NW = 3'd7
  } dir_e;

  localparam int NUM_ORI = 4;
  localparam int ORI_W   = 2;

  // orientation index: 0 diag A, 1 vertical, 2 horizontal, 3 diag B
  function automatic dir_e ori_to_dir(input logic [ORI_W-1:0] ori, input logic neg);
    dir_e d;
    unique case (ori)
      2'd0:    d = neg ? DIR_SW : DIR_NE;
      2'd1:    d = neg ? DIR_S  : DIR_N;
      2'd2:    d = neg ? DIR_W  : DIR_E;
      default: d = neg ? DIR_SE : DIR_NW;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sobel_deriv.sv
module sobel_deriv #(
  parameter int PIX_W = 8,
  parameter int DER_W = 12
) (
  input  logic [9*PIX_W-1:0]       win_i,
  output logic signed [DER_W-1:0]  deriv_o [sobel_pkg::NUM_ORI]
);
  localparam int PAD_W = DER_W - PIX_W;

  logic signed [DER_W-1:0] p [3][3];

  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      assign p[r][c] = $signed({{PAD_W{1'b0}}, win_i[(3*r+c)*PIX_W +: PIX_W]});
    end
  end

  always_comb begin
    deriv_o[0] = (p[0][1] + (p[0][2] <<< 1) + p[1][2]) - (p[1][0] + (p[2][0] <<< 1) + p[2][1]);
    deriv_o[1] = (p[0][0] + (p[0][1] <<< 1) + p[0][2]) - (p[2][0] + (p[2][1] <<< 1) + p[2][2]);
    deriv_o[2] = (p[0][2] + (p[1][2] <<< 1) + p[2][2]) - (p[0][0] + (p[1][0] <<< 1) + p[2][0]);
    deriv_o[3] = (p[1][0] + (p[0][0] <<< 1) + p[0][1]) - (p[2][1] + (p[2][2] <<< 1) + p[1][2]);
  end

endmodule

// File: rtl/sobel_absmax.sv
module sobel_absmax #(
  parameter int DER_W = 12
) (
  input  logic signed [DER_W-1:0]         deriv_i [sobel_pkg::NUM_ORI],
  output logic [DER_W-1:0]                mag_o   [sobel_pkg::NUM_ORI],
  output logic [sobel_pkg::ORI_W-1:0]     max_ori_o,
  output logic [DER_W-1:0]                max_mag_o
);
  import sobel_pkg::*;

  for (genvar i = 0; i < NUM_ORI; i++) begin : g_abs
    assign mag_o[i] = deriv_i[i][DER_W-1] ? DER_W'(-deriv_i[i]) : DER_W'(deriv_i[i]);
  end

  // strict compare keeps the earliest orientation on ties
  always_comb begin
    max_ori_o = '0;
    max_mag_o = mag_o[0];
    for (int i = 1; i < NUM_ORI; i++) begin
      if (mag_o[i] > max_mag_o) begin
        max_mag_o = mag_o[i];
        max_ori_o = ORI_W'(i);
      end
    end
  end

endmodule

// File: rtl/sobel_decide.sv
module sobel_decide #(
  parameter int DER_W  = 12,
  parameter int THRESH = 80
) (
  input  logic [DER_W-1:0]               mag_i   [sobel_pkg::NUM_ORI],
  input  logic [sobel_pkg::NUM_ORI-1:0]  neg_i,
  input  logic [sobel_pkg::ORI_W-1:0]    max_ori_i,
  input  logic [DER_W-1:0]               max_mag_i,
  output logic                           hit_o,
  output logic [2:0]                     dir_o
);
  import sobel_pkg::*;

  localparam int SUM_W = DER_W + 1;

  logic [ORI_W-1:0] perp_ori;
  logic [DER_W-1:0] perp_mag;
  logic [SUM_W-1:0] score;

  // pairs 0<->3 and 1<->2 are bitwise complements
  assign perp_ori = ~max_ori_i;
  assign perp_mag = mag_i[perp_ori];
  assign score    = SUM_W'(max_mag_i) + SUM_W'(perp_mag >> 3);
  assign hit_o    = (score >= SUM_W'(THRESH));
  assign dir_o    = hit_o ? 3'(ori_to_dir(max_ori_i, neg_i[max_ori_i])) : 3'd0;

endmodule

// File: rtl/sobel_edge_classifier.sv
module sobel_edge_classifier #(
  parameter int PIX_W  = 8,
  parameter int DER_W  = 12,
  parameter int THRESH = 80
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               win_valid_i,
  input  logic [9*PIX_W-1:0] win_i,
  output logic               edge_valid_o,
  output logic               edge_o,
  output logic [2:0]         dir_o
);
  import sobel_pkg::*;

  logic signed [DER_W-1:0] deriv_c  [NUM_ORI];
  logic signed [DER_W-1:0] s1_deriv [NUM_ORI];
  logic                    s1_valid;
  logic [DER_W-1:0]        mag      [NUM_ORI];
  logic [NUM_ORI-1:0]      neg;
  logic [ORI_W-1:0]        max_ori;
  logic [DER_W-1:0]        max_mag;
  logic                    hit;
  logic [2:0]              dir_c;

  sobel_deriv #(.PIX_W(PIX_W), .DER_W(DER_W)) u_deriv (
    .win_i   (win_i),
    .deriv_o (deriv_c)
  );

  // stage 1: derivatives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      for (int i = 0; i < NUM_ORI; i++) s1_deriv[i] <= '0;
    end else begin
      s1_valid <= win_valid_i;
      if (win_valid_i) begin
        for (int i = 0; i < NUM_ORI; i++) s1_deriv[i] <= deriv_c[i];
      end
    end
  end

  for (genvar i = 0; i < NUM_ORI; i++) begin : g_sign
    assign neg[i] = s1_deriv[i][DER_W-1];
  end

  sobel_absmax #(.DER_W(DER_W)) u_absmax (
    .deriv_i   (s1_deriv),
    .mag_o     (mag),
    .max_ori_o (max_ori),
    .max_mag_o (max_mag)
  );

  sobel_decide #(.DER_W(DER_W), .THRESH(THRESH)) u_decide (
    .mag_i     (mag),
    .neg_i     (neg),
    .max_ori_i (max_ori),
    .max_mag_i (max_mag),
    .hit_o     (hit),
    .dir_o     (dir_c)
  );

  // stage 2: classification
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_valid_o <= 1'b0;
      edge_o       <= 1'b0;
      dir_o        <= 3'd0;
    end else begin
      edge_valid_o <= s1_valid;
      edge_o       <= s1_valid & hit;
      dir_o        <= s1_valid ? dir_c : 3'd0;
    end
  end

endmodule

// File: rtl/sobel_edge_classifier_chk.sv
module sobel_edge_classifier_chk #(
  parameter int DER_W = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    win_valid_i,
  input logic                    s1_valid_i,
  input logic signed [DER_W-1:0] s1_d0_i,
  input logic signed [DER_W-1:0] s1_d1_i,
  input logic signed [DER_W-1:0] s1_d2_i,
  input logic signed [DER_W-1:0] s1_d3_i,
  input logic                    edge_valid_o,
  input logic                    edge_o,
  input logic [2:0]              dir_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  a_r6_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (edge_valid_o == $past(win_valid_i, 2)));

  a_r5_no_edge_dir_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_o |-> (dir_o == 3'd0));

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_valid_o |-> (!edge_o && dir_o == 3'd0));

  a_r1_flat_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_i && s1_d0_i == '0 && s1_d1_i == '0 && s1_d2_i == '0 && s1_d3_i == '0)
    |=> !edge_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_clear: assert (!edge_valid_o && !edge_o && dir_o == 3'd0);
    end
  end

endmodule

bind sobel_edge_classifier sobel_edge_classifier_chk #(.DER_W(DER_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .win_valid_i  (win_valid_i),
  .s1_valid_i   (s1_valid),
  .s1_d0_i      (s1_deriv[0]),
  .s1_d1_i      (s1_deriv[1]),
  .s1_d2_i      (s1_deriv[2]),
  .s1_d3_i      (s1_deriv[3]),
  .edge_valid_o (edge_valid_o),
  .edge_o       (edge_o),
  .dir_o        (dir_o)
);

// File: tb/sobel_edge_classifier_tb.sv
module sobel_edge_classifier_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        win_valid_i = 1'b0;
  logic [71:0] win_i = '0;
  logic        edge_valid_o;
  logic        edge_o;
  logic [2:0]  dir_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  sobel_edge_classifier u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .win_valid_i  (win_valid_i),
    .win_i        (win_i),
    .edge_valid_o (edge_valid_o),
    .edge_o       (edge_o),
    .dir_o        (dir_o)
  );

  // {t22,t21,t20,t12,t11,t10,t02,t01,t00}, expected edge, expected dir
  typedef struct packed {
    logic [71:0] win;
    logic        exp_edge;
    logic [2:0]  exp_dir;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{{8'd50,8'd50,8'd50,8'd50,8'd50,8'd50,8'd50,8'd50,8'd50}, 1'b0, 3'b000}, // flat
    '{{8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd100,8'd100,8'd100},    1'b1, 3'b000}, // N
    '{{8'd100,8'd100,8'd100,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0},    1'b1, 3'b100}, // S
    '{{8'd100,8'd0,8'd0,8'd100,8'd0,8'd0,8'd100,8'd0,8'd0},    1'b1, 3'b010}, // E
    '{{8'd0,8'd0,8'd100,8'd0,8'd0,8'd100,8'd0,8'd0,8'd100},    1'b1, 3'b110}, // W
    '{{8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd100,8'd0,8'd0},        1'b1, 3'b001}, // NE
    '{{8'd0,8'd0,8'd100,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0},        1'b1, 3'b101}, // SW
    '{{8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd100},        1'b1, 3'b111}, // NW
    '{{8'd50,8'd50,8'd0,8'd50,8'd0,8'd0,8'd0,8'd0,8'd0},       1'b1, 3'b011}, // SE
    '{{8'd100,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0},        1'b1, 3'b011}, // SE single
    '{{8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd100,8'd100,8'd0},      1'b1, 3'b001}, // tie A vs vertical
    '{{8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd20,8'd20,8'd20},       1'b1, 3'b000}, // score 80
    '{{8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd20,8'd20,8'd19},       1'b0, 3'b000}, // score 79
    '{{8'd0,8'd0,8'd0,8'd32,8'd0,8'd0,8'd0,8'd36,8'd0},        1'b1, 3'b000}, // 72+64/8
    '{{8'd0,8'd0,8'd0,8'd31,8'd0,8'd0,8'd0,8'd36,8'd0},        1'b0, 3'b000}, // 72+62/8
    '{{8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd255,8'd255,8'd255},    1'b1, 3'b000}, // full scale
    '{{8'd255,8'd255,8'd255,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0},    1'b1, 3'b100}  // full scale
  };

  task automatic check_out(input string req, input logic ev, input logic ee, input logic [2:0] ed);
    checks++;
    if (edge_valid_o !== ev || edge_o !== ee || dir_o !== ed) begin
      errors++;
      $display("FAIL %s: got valid=%b edge=%b dir=%b, expected valid=%b edge=%b dir=%b",
               req, edge_valid_o, edge_o, dir_o, ev, ee, ed);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R8: reset state
    repeat (3) @(negedge clk_i);
    check_out("R8 reset", 1'b0, 1'b0, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R8 after release", 1'b0, 1'b0, 3'b000);

    // R1 R2 R3 R4 R5 R6: back-to-back windows, result two clocks later
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2)
        check_out($sformatf("R1 R2 R3 R4 R5 vector %0d", i - 2), 1'b1,
                  VEC[i-2].exp_edge, VEC[i-2].exp_dir);
      if (i < NV) begin
        win_i = VEC[i].win;
        win_valid_i = 1'b1;
      end else begin
        win_valid_i = 1'b0;
      end
    end

    // R6: single window latency
    @(negedge clk_i);
    win_i = VEC[3].win;
    win_valid_i = 1'b1;
    @(negedge clk_i);
    win_valid_i = 1'b0;
    check_out("R6 one clock", 1'b0, 1'b0, 3'b000);
    @(negedge clk_i);
    check_out("R6 two clocks", 1'b1, 1'b1, 3'b010);
    @(negedge clk_i);
    check_out("R6 drop", 1'b0, 1'b0, 3'b000);

    // R7: strong edge presented without valid
    win_i = VEC[1].win;
    win_valid_i = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      check_out("R7 invalid window", 1'b0, 1'b0, 3'b000);
    end

    // R8: reset discards an in-flight window
    win_i = VEC[2].win;
    win_valid_i = 1'b1;
    @(negedge clk_i);
    win_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check_out("R8 async clear", 1'b0, 1'b0, 3'b000);
    @(negedge clk_i);
    check_out("R8 held", 1'b0, 1'b0, 3'b000);
    rst_ni = 1'b1;
    repeat (2) begin
      @(negedge clk_i);
      check_out("R8 flushed", 1'b0, 1'b0, 3'b000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule